// File: doc/BRIEF.md
# Dual-Channel Sampling ADC Serial Readout Controller

This block sits on the host side of a serial link to a converter that samples two analog channels at the same instant and returns two 12-bit results. It produces the active-low chip select and the serial clock. It captures the returned bits from two data lines, A and B, and delivers both results together with a one-cycle strobe.

Two framing styles are supported. In parallel framing, both data lines are captured in one short frame of 14 or 16 serial clocks, so each line needs its own receive path. In single-line framing, one data line carries a 32-clock frame that holds its own converter's result followed by the other converter's result, so only one receive path is needed. The serial clock is the system clock divided by a programmable even ratio. A programmable quiet time keeps chip select high between frames, and any 1 captured in a position that must be zero raises a sticky error flag.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, cs_n and sclk are high, valid is low, res_a and res_b are zero, and frame_err is low.
- R2: A frame has exactly 14 rising sclk edges for mode 2'b00, 16 for mode 2'b01, and 32 for mode 2'b10 and 2'b11. mode and div_half are sampled only when a frame is accepted, and a change to them during a frame has no effect on that frame.
- R3: sclk is high whenever cs_n is high. Within a frame, sclk first falls h system clocks after cs_n falls. After that, every low phase and every high phase lasts h system clocks, where h is div_half, or 1 when div_half is 0. The clock never pauses inside a frame.
- R4: Data lines are sampled on each rising edge of sclk. Frame bit k is the bit sampled on rising edge k, counting from 0, and the 12-bit results are taken most significant bit first.
- R5: In modes 2'b00 and 2'b01, frame bits 2 to 13 of line A form res_a and the same bits of line B form res_b.
- R6: In mode 2'b10, line A alone is read. Its frame bits 2 to 13 form res_a and bits 18 to 29 form res_b. In mode 2'b11, line B alone is read. Its bits 2 to 13 form res_b and bits 18 to 29 form res_a.
- R7: valid is high for exactly one cycle. That cycle is the one in which cs_n rises, and the new results appear in it. res_a and res_b hold their values until the next valid.
- R8: A frame starts only on a start pulse seen when cs_n has been high for at least max(quiet,1) system clocks. If start is held high, the gap between frames is exactly max(quiet,1) clocks. A start seen too early or during a frame is dropped, not held.
- R9: frame_err becomes set, and stays set, when a 1 is captured in a zero position on a line being read. The zero positions are bits 0 and 1 in every mode, bits 14 and 15 in modes 2'b01, 2'b10 and 2'b11, and bits 16, 17, 30 and 31 in modes 2'b10 and 2'b11. The line that is not read in single-line framing is never checked. A one-cycle err_clr pulse clears the flag, and a new error in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a frame |
| mode | input | 2 | Framing select: 00 parallel-14, 01 parallel-16, 10 single-line on A, 11 single-line on B |
| div_half | input | DIV_W | Half period of sclk in system clocks (0 acts as 1) |
| quiet | input | QUIET_W | Minimum cs_n high time between frames, in system clocks |
| err_clr | input | 1 | Clears the sticky framing error |
| sdata_a | input | 1 | Serial data line A |
| sdata_b | input | 1 | Serial data line B |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| valid | output | 1 | One-cycle strobe marking new results |
| res_a | output | RES_W | Result of converter A |
| res_b | output | RES_W | Result of converter B |
| frame_err | output | 1 | Sticky framing error flag |

## Verification
Both results and the error flag are due in the same cycle that the last rising sclk edge and the rising cs_n appear. This is 2·len·h system clocks after the cycle in which start is accepted. The monitor reads them on the falling clock edge of that valid cycle and compares them against the queued expectation. The bench's converter model changes its data lines on the falling clock edge that follows each sclk fall. This leaves a full half period before the sampling edge. Gaps, phase lengths and the first-fall delay are counted in system clocks at falling clock edges, so each count equals the number of register cycles the design holds a level.

// File: rtl/dual_adc_reader.sv
`timescale 1ns/1ps
module dual_adc_reader #(
  parameter int RES_W   = 12,
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         mode,
  input  logic [DIV_W-1:0]   div_half,
  input  logic [QUIET_W-1:0] quiet,
  input  logic               err_clr,
  input  logic               sdata_a,
  input  logic               sdata_b,
  output logic               cs_n,
  output logic               sclk,
  output logic               valid,
  output logic [RES_W-1:0]   res_a,
  output logic [RES_W-1:0]   res_b,
  output logic               frame_err
);
  localparam int SHORT_LEN = RES_W + 2;
  localparam int MID_LEN   = RES_W + 4;
  localparam int LONG_LEN  = 2 * MID_LEN;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);
  localparam logic [1:0] M_PAR_S = 2'b00;
  localparam logic [1:0] M_PAR_M = 2'b01;
  localparam logic [1:0] M_ONE_A = 2'b10;
  localparam logic [1:0] M_ONE_B = 2'b11;

  logic [1:0]          mode_q;
  logic [DIV_W-1:0]    half_q, ph;
  logic [CNT_W-1:0]    nbits, len_m1;
  logic [QUIET_W-1:0]  quiet_cnt;
  logic [LONG_LEN-1:0] sh_p;
  logic [MID_LEN-1:0]  sh_q;
  logic [RES_W-1:0]    first_w, second_w, new_a, new_b;
  logic                zero_bad;

  wire tick  = !cs_n && (ph == half_q - 1'b1);
  wire rise  = tick && !sclk;
  wire bit_p = (mode_q == M_ONE_B) ? sdata_b : sdata_a;
  wire [LONG_LEN-1:0] fp = {sh_p[LONG_LEN-2:0], bit_p};
  wire [MID_LEN-1:0]  fq = {sh_q[MID_LEN-2:0], sdata_b};
  wire last  = rise && (nbits == len_m1);
  wire ready = quiet_cnt >= quiet;

  always_comb begin
    case (mode_q)
      M_PAR_S: len_m1 = CNT_W'(SHORT_LEN - 1);
      M_PAR_M: len_m1 = CNT_W'(MID_LEN - 1);
      default: len_m1 = CNT_W'(LONG_LEN - 1);
    endcase
  end

  always_comb begin
    first_w  = fp[LONG_LEN-3 -: RES_W];
    second_w = fp[RES_W+1:2];
    case (mode_q)
      M_PAR_S: begin
        new_a    = fp[RES_W-1:0];
        new_b    = fq[RES_W-1:0];
        zero_bad = |{fp[SHORT_LEN-1 -: 2], fq[SHORT_LEN-1 -: 2]};
      end
      M_PAR_M: begin
        new_a    = fp[RES_W+1:2];
        new_b    = fq[RES_W+1:2];
        zero_bad = |{fp[MID_LEN-1 -: 2], fp[1:0], fq[MID_LEN-1 -: 2], fq[1:0]};
      end
      default: begin
        new_a    = (mode_q == M_ONE_A) ? first_w : second_w;
        new_b    = (mode_q == M_ONE_A) ? second_w : first_w;
        zero_bad = |{fp[LONG_LEN-1 -: 2], fp[MID_LEN+1 -: 4], fp[1:0]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      valid     <= 1'b0;
      res_a     <= '0;
      res_b     <= '0;
      mode_q    <= M_PAR_S;
      half_q    <= DIV_W'(1);
      ph        <= '0;
      nbits     <= '0;
      quiet_cnt <= '0;
      sh_p      <= '0;
      sh_q      <= '0;
    end else begin
      valid <= 1'b0;
      if (cs_n) begin
        if (quiet_cnt != '1) quiet_cnt <= quiet_cnt + 1'b1;
        if (start && ready) begin
          cs_n   <= 1'b0;
          mode_q <= mode;
          half_q <= (div_half == '0) ? DIV_W'(1) : div_half;
          ph     <= '0;
          nbits  <= '0;
        end
      end else if (tick) begin
        ph   <= '0;
        sclk <= ~sclk;
        if (rise) begin
          sh_p  <= fp;
          sh_q  <= fq;
          nbits <= nbits + 1'b1;
          if (last) begin
            cs_n      <= 1'b1;
            valid     <= 1'b1;
            res_a     <= new_a;
            res_b     <= new_b;
            quiet_cnt <= QUIET_W'(1);
          end
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_err <= 1'b0;
    else        frame_err <= (last && zero_bad) || (frame_err && !err_clr);
  end
endmodule

// File: rtl/dual_adc_reader_chk.sv
`timescale 1ns/1ps
module dual_adc_reader_chk #(
  parameter int RES_W   = 12,
  parameter int QUIET_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode,
  input logic [QUIET_W-1:0] quiet,
  input logic               err_clr,
  input logic               cs_n,
  input logic               sclk,
  input logic               valid,
  input logic [RES_W-1:0]   res_a,
  input logic [RES_W-1:0]   res_b,
  input logic               frame_err
);
  logic [QUIET_W:0] hi_cnt;
  logic [7:0]       rise_cnt, exp_len;
  logic [1:0]       mode_c;
  logic             sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      rise_cnt <= '0;
      mode_c   <= 2'b00;
      sclk_d   <= 1'b1;
    end else begin
      sclk_d <= sclk;
      if (cs_n) begin
        if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
        mode_c   <= mode;
        rise_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (mode_c)
      2'b00:   exp_len = 8'(RES_W + 2);
      2'b01:   exp_len = 8'(RES_W + 4);
      default: exp_len = 8'(2 * (RES_W + 4));
    endcase
  end

  a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  a_r3_sclk_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> !$past(cs_n));
  a_r2_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rise_cnt + 8'd1 == exp_len));
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  a_r7_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n));
  a_r7_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(res_a) && $stable(res_b)));
  a_r8_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && $stable(quiet)) |-> (hi_cnt >= {1'b0, quiet}));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clr) |=> frame_err);
  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !valid && cs_n) |=> !frame_err);
endmodule

bind dual_adc_reader dual_adc_reader_chk #(.RES_W(RES_W), .QUIET_W(QUIET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .quiet(quiet), .err_clr(err_clr),
  .cs_n(cs_n), .sclk(sclk), .valid(valid), .res_a(res_a), .res_b(res_b),
  .frame_err(frame_err)
);

// File: tb/dual_adc_reader_bench.sv
`timescale 1ns/1ps
module dual_adc_reader_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, err_clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] div_half = 8'd2, quiet = 8'd4;
  logic sdata_a = 1'b0, sdata_b = 1'b0;
  logic cs_n, sclk, valid, frame_err;
  logic [11:0] res_a, res_b;

  dual_adc_reader u_dual_adc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .div_half(div_half),
    .quiet(quiet), .err_clr(err_clr), .sdata_a(sdata_a), .sdata_b(sdata_b),
    .cs_n(cs_n), .sclk(sclk), .valid(valid), .res_a(res_a), .res_b(res_b),
    .frame_err(frame_err)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic [11:0] a; logic [11:0] b; logic err; int len; int half; logic [1:0] md; } exp_t;
  exp_t q[$];
  exp_t e;
  int checks = 0, failures = 0;
  logic err_model = 1'b0;
  logic [31:0] wa = '0, wb = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: next bit appears after each sclk fall
  int didx = 0;
  logic dev_prev = 1'b1;
  always @(negedge clk) begin
    if (cs_n) didx = 0;
    else if (dev_prev && !sclk && didx < 32) begin
      sdata_a = wa[31-didx];
      sdata_b = wb[31-didx];
      didx++;
    end
    dev_prev = sclk;
  end

  // monitor / scoreboard
  int lo_run = 0, hi0 = 0, rises = 0, cs_falls = 0;
  logic seen_low = 1'b0, phase_bad = 1'b0, prev_valid = 1'b0, prev_cs = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (prev_cs && !cs_n) cs_falls++;
    if (!cs_n && !sclk) begin lo_run++; seen_low = 1'b1; end
    else if (lo_run != 0) begin
      rises++;
      if (q.size() > 0 && lo_run != q[0].half) phase_bad = 1'b1;
      lo_run = 0;
    end
    if (!cs_n && sclk && !seen_low) hi0++;
    if (prev_valid) chk("R7 valid lasts one cycle", valid, 0);
    if (valid) begin
      if (q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R7 unexpected valid actual=1 expected=0");
      end else begin
        e = q.pop_front();
        chk("R7 cs_n rises with valid", cs_n, 1);
        chk("R2 rising edges per frame", rises, e.len);
        chk("R3 phase length", phase_bad, 0);
        chk("R3 first fall delay", hi0, e.half);
        if (e.md[1]) begin
          chk("R6 R4 res_a", res_a, e.a);
          chk("R6 R4 res_b", res_b, e.b);
        end else begin
          chk("R5 R4 res_a", res_a, e.a);
          chk("R5 R4 res_b", res_b, e.b);
        end
        chk("R9 frame_err", frame_err, e.err);
      end
      rises = 0; hi0 = 0; seen_low = 1'b0; phase_bad = 1'b0;
    end
    prev_valid = valid;
    prev_cs = cs_n;
  end

  function automatic int len_of(input logic [1:0] md);
    return (md == 2'b00) ? 14 : (md == 2'b01) ? 16 : 32;
  endfunction

  task automatic expect_frame(input logic [1:0] md, input logic [11:0] ca, input logic [11:0] cb,
                              input logic [31:0] ma, input logic [31:0] mb, input logic [7:0] dh);
    logic [31:0] pm;
    logic hit;
    exp_t it;
    pm = (md == 2'b00) ? 32'hC000_0000 : (md == 2'b01) ? 32'hC003_0000 : 32'hC003_C003;
    hit = (md == 2'b10) ? |(ma & pm) : (md == 2'b11) ? |(mb & pm) : |((ma | mb) & pm);
    err_model = err_model | hit;
    wa = {2'b00, ca, 4'b0000, cb, 2'b00} ^ ma;
    wb = {2'b00, cb, 4'b0000, ca, 2'b00} ^ mb;
    it.a = ca; it.b = cb; it.err = err_model; it.len = len_of(md);
    it.half = (dh == 0) ? 1 : int'(dh); it.md = md;
    q.push_back(it);
  endtask

  task automatic run_frame(input logic [1:0] md, input logic [11:0] ca, input logic [11:0] cb,
                           input logic [31:0] ma, input logic [31:0] mb, input logic [7:0] dh,
                           input bit disturb);
    expect_frame(md, ca, cb, ma, mb, dh);
    mode = md; div_half = dh;
    @(negedge clk) start = 1'b1;
    while (cs_n) @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      start = 1'b1; mode = ~md; div_half = dh + 8'd3;   // R2: ignored mid-frame
      @(negedge clk) start = 1'b0;
    end
    while (!cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_err();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    err_model = 1'b0;
    chk("R9 cleared by err_clr", frame_err, 0);
  endtask

  task automatic quiet_gap(input logic [7:0] qv);
    int g;
    quiet = qv;
    expect_frame(2'b00, 12'h5A3, 12'hA5C, '0, '0, 8'd1);
    expect_frame(2'b00, 12'h5A3, 12'hA5C, '0, '0, 8'd1);
    mode = 2'b00; div_half = 8'd1;
    @(negedge clk) start = 1'b1;
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    g = 0;
    while (cs_n) begin g++; @(negedge clk); end
    start = 1'b0;
    chk("R8 gap with start held", g, (qv == 0) ? 1 : int'(qv));
    while (!cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f0;
    logic [11:0] ha;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sclk", sclk, 1);
    chk("R1 valid", valid, 0);
    chk("R1 res_a", res_a, 0);
    chk("R1 res_b", res_b, 0);
    chk("R1 frame_err", frame_err, 0);

    run_frame(2'b00, 12'hA5C, 12'h3F1, '0, '0, 8'd2, 0);
    run_frame(2'b01, 12'h123, 12'hFED, '0, '0, 8'd1, 0);
    run_frame(2'b00, 12'h800, 12'h001, '0, '0, 8'd0, 0);   // R3: div 0 acts as 1
    run_frame(2'b10, 12'h6B2, 12'h94D, '0, '0, 8'd3, 0);
    run_frame(2'b11, 12'h0F0, 12'hF0F, '0, '0, 8'd2, 0);
    run_frame(2'b01, 12'hFFF, 12'h000, '0, '0, 8'd2, 0);
    run_frame(2'b10, 12'h000, 12'hFFF, '0, '0, 8'd1, 0);
    run_frame(2'b00, 12'h3C3, 12'hC3C, '0, '0, 8'd4, 1);   // R2: mode/div change ignored

    // R7: results hold between frames
    ha = res_a;
    repeat (15) @(negedge clk);
    chk("R7 res_a held", res_a, ha);

    // R9: bit 14 not part of a 14-clock frame
    run_frame(2'b00, 12'h111, 12'h222, 32'h0002_0000, '0, 8'd1, 0);
    run_frame(2'b00, 12'h111, 12'h222, '0, 32'h4000_0000, 8'd1, 0);  // leading on B
    run_frame(2'b01, 12'h333, 12'h444, '0, '0, 8'd1, 0);            // stays set
    clear_err();
    run_frame(2'b01, 12'h555, 12'h666, 32'h0001_0000, '0, 8'd2, 0);  // trailing on A
    clear_err();
    run_frame(2'b11, 12'h777, 12'h888, 32'hC003_C003, '0, 8'd1, 0);  // unread line
    run_frame(2'b11, 12'h999, 12'hAAA, '0, 32'h0000_0002, 8'd1, 0);  // bit 30 on B
    clear_err();
    run_frame(2'b10, 12'hBBB, 12'hCCC, 32'h0000_8000, '0, 8'd1, 0);  // bit 16 on A
    clear_err();

    // R8: early start and mid-frame start are dropped
    quiet = 8'd20;
    run_frame(2'b00, 12'h246, 12'h8AC, '0, '0, 8'd1, 0);
    f0 = cs_falls;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 early start dropped", cs_falls, f0);
    quiet = 8'd2;
    run_frame(2'b00, 12'h135, 12'h7F9, '0, '0, 8'd2, 1);
    f0 = cs_falls;
    repeat (30) @(negedge clk);
    chk("R8 mid-frame start dropped", cs_falls, f0);

    quiet_gap(8'd6);
    quiet_gap(8'd0);

    repeat (5) @(negedge clk);
    chk("R7 all frames delivered", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule